// File: doc/BRIEF.md
# TDM Audio Slot Transmitter

This block is a clock-master serial audio transmitter. From the system clock it divides down a bit clock, produces the matching frame clock, and shifts out up to `NUM_CH` parallel channel samples on one data line. Each channel has its own enable bit and its own slot number. Channels can therefore be placed in any order, and slots can be left empty. The frame length in bit clocks, the slot length and the word length are run-time inputs. A two-bit format input selects one of four framings: two pulse-style framings and two half-frame framings.

One sample set (one word per channel, all at the same rate) is offered through a valid/ready handshake. It is held in a staging register and moved into the transmit bank at the start of the next frame, so one set goes out per frame. A frame that starts with no staged set carries zeros. A registered flag reports a slot map that cannot be sent: a shared slot, a slot that overruns its frame or half-frame, or a zero slot length.

Top module: `tdm_slot_tx`

## Requirements
- R1: The bit clock idles high in reset and toggles every `DIV_HALF` system clocks, so its period is `2*DIV_HALF` system clocks. Data and frame clock change only when the bit clock falls.
- R2: With format code 1 (pulse, no delay), the frame clock is high for bit 0 of the frame only, and slot k starts at bit k*slot_len.
- R3: With format code 0 (pulse, one-bit delay), the frame clock is high for bit 0 of the frame only, and slot k starts at bit 1+k*slot_len.
- R4: With format code 3 (half-frame, no delay), the frame clock is low for bits below frame_len/2 (rounded down) and high for the rest. Slot 2j starts at bit j*slot_len of the first half, and slot 2j+1 starts at bit j*slot_len of the second half.
- R5: With format code 2 (half-frame, one-bit delay), the frame clock is high in the first half and low in the second half. Every slot starts one bit later than in R4, and the first bit of each half drives 0.
- R6: Channel c sends only when enable bit c is set, in the slot given by `cfg_ch_slot[c*SLOT_W +: SLOT_W]`. The mapping may be in any order. Disabled channels send nothing, and with no channel enabled the data line stays 0.
- R7: Within a slot, bit b carries `sample[SAMPLE_W-1-b]` (MSB first, MSB-aligned sample) for b below word_len. Later bits of the slot, and every bit of an unused slot or of a bit outside any slot, drive 0.
- R8: `s_ready` is high while the staging register is empty and drops the cycle after an accepted transfer. A set accepted during frame n is sent in frame n+1. A frame that starts with nothing staged sends all zeros. Channel c's sample is `s_data[c*SAMPLE_W +: SAMPLE_W]`.
- R9: `cfg_err` rises one clock after the configuration has one of these faults: two enabled channels share a slot; an enabled slot ends past the frame (pulse formats) or past its half (half formats, with the first half being frame_len/2 bits long); or slot_len is 0. It is low otherwise.
- R10: In reset, `bclk` is 1, `lrclk`, `txd` and `cfg_err` are 0, and `s_ready` is 1. The first falling bit clock after reset begins bit 0 of frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fmt | input | 2 | Framing: 0 pulse+delay, 1 pulse, 2 half-frame+delay, 3 half-frame |
| cfg_frame_len | input | FRAME_W | Bit clocks per frame |
| cfg_slot_len | input | SLEN_W | Bit clocks per slot |
| cfg_word_len | input | $clog2(SAMPLE_W+1) | Valid data bits per slot |
| cfg_ch_en | input | NUM_CH | Per-channel enable |
| cfg_ch_slot | input | NUM_CH*SLOT_W | Per-channel slot number |
| s_valid | input | 1 | Sample set offered |
| s_ready | output | 1 | Staging register empty |
| s_data | input | NUM_CH*SAMPLE_W | Sample set, channel c in field c |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Frame clock |
| txd | output | 1 | Serial data |
| cfg_err | output | 1 | Slot map cannot be sent |

## Verification
The bench builds the block with eight channels, 16-bit samples, an 8-bit frame length and `DIV_HALF` of 2. The divide-by-four bit clock exercises the divider counter rather than a bare toggle, while the frame lengths of 48 and 64 bits keep every frame short enough to capture three frames per scenario. With eight channels, the half-frame formats can place even and odd slots on both halves, the slot map can be shuffled, and enabled and disabled channels can carry data side by side. A word length shorter than the slot length exposes the zero padding.

// File: rtl/tdm_tx_pkg.sv
`timescale 1ns/1ps
package tdm_tx_pkg;
   typedef enum logic [1:0] {
      FMT_PULSE_LATE = 2'd0,
      FMT_PULSE      = 2'd1,
      FMT_HALF_LATE  = 2'd2,
      FMT_HALF       = 2'd3
   } tdm_fmt_e;

   function automatic logic fmt_is_pulse(input logic [1:0] f);
      return (f == FMT_PULSE_LATE) || (f == FMT_PULSE);
   endfunction

   function automatic logic fmt_is_late(input logic [1:0] f);
      return (f == FMT_PULSE_LATE) || (f == FMT_HALF_LATE);
   endfunction
endpackage

// File: rtl/tdm_tx_bclkgen.sv
`timescale 1ns/1ps
module tdm_tx_bclkgen #(
   parameter int DIV_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic bclk,
   output logic fall_tick
);
   localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

   logic [DW-1:0] cnt_q;
   logic          wrap;

   assign wrap      = (cnt_q == DW'(DIV_HALF - 1));
   assign fall_tick = wrap & bclk;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         bclk  <= 1'b1;
      end else if (wrap) begin
         cnt_q <= '0;
         bclk  <= ~bclk;
      end else begin
         cnt_q <= cnt_q + DW'(1);
      end
   end
endmodule

// File: rtl/tdm_tx_seq.sv
`timescale 1ns/1ps
module tdm_tx_seq
   import tdm_tx_pkg::*;
#(
   parameter int FRAME_W = 9,
   parameter int SLEN_W  = 6,
   parameter int LOC_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic [1:0]         fmt,
   input  logic [FRAME_W-1:0] frame_len,
   input  logic [SLEN_W-1:0]  slot_len,
   output logic               running,
   output logic               pos_zero,
   output logic               second_half,
   output logic               in_region,
   output logic [SLEN_W-1:0]  bis,
   output logic [LOC_W-1:0]   loc,
   output logic               frame_start
);
   logic [FRAME_W-1:0] pos_q, np, half_len, seg;
   logic               first_q, half_q, reg_q, n_half, n_reg, late, pulse;
   logic [SLEN_W-1:0]  bis_q, n_bis;
   logic [LOC_W-1:0]   loc_q, n_loc;

   always_comb begin
      pulse    = fmt_is_pulse(fmt);
      late     = fmt_is_late(fmt);
      half_len = frame_len >> 1;
      np       = (first_q || pos_q == frame_len - FRAME_W'(1)) ? '0 : pos_q + FRAME_W'(1);
      n_half   = !pulse && (np >= half_len);
      seg      = n_half ? half_len : '0;
      n_reg    = reg_q;
      n_bis    = bis_q;
      n_loc    = loc_q;
      if (np == seg + FRAME_W'(late)) begin
         n_reg = 1'b1;
         n_bis = '0;
         n_loc = '0;
      end else if (late && np == seg) begin
         n_reg = 1'b0;
      end else if (reg_q) begin
         if (bis_q == slot_len - SLEN_W'(1)) begin
            n_bis = '0;
            if (loc_q != '1) n_loc = loc_q + LOC_W'(1);
         end else begin
            n_bis = bis_q + SLEN_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q   <= '0;
         first_q <= 1'b1;
         half_q  <= 1'b0;
         reg_q   <= 1'b0;
         bis_q   <= '0;
         loc_q   <= '0;
      end else if (tick) begin
         pos_q   <= np;
         first_q <= 1'b0;
         half_q  <= n_half;
         reg_q   <= n_reg;
         bis_q   <= n_bis;
         loc_q   <= n_loc;
      end
   end

   assign frame_start = tick && (np == '0);
   assign running     = !first_q;
   assign pos_zero    = (pos_q == '0);
   assign second_half = half_q;
   assign in_region   = reg_q;
   assign bis         = bis_q;
   assign loc         = loc_q;
endmodule

// File: rtl/tdm_tx_cfgchk.sv
`timescale 1ns/1ps
module tdm_tx_cfgchk
   import tdm_tx_pkg::*;
#(
   parameter int NUM_CH  = 8,
   parameter int SLOT_W  = 3,
   parameter int FRAME_W = 9,
   parameter int SLEN_W  = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [1:0]               fmt,
   input  logic [FRAME_W-1:0]       frame_len,
   input  logic [SLEN_W-1:0]        slot_len,
   input  logic [NUM_CH-1:0]        ch_en,
   input  logic [NUM_CH*SLOT_W-1:0] ch_slot,
   output logic                     err
);
   localparam int EW = FRAME_W + SLEN_W + SLOT_W + 2;

   logic          bad, pulse;
   logic [EW-1:0] lim, endp, half_e, fl_e, loc_e;

   always_comb begin
      pulse  = fmt_is_pulse(fmt);
      fl_e   = EW'(frame_len);
      half_e = EW'(frame_len >> 1);
      bad    = (slot_len == '0);
      lim    = '0;
      endp   = '0;
      loc_e  = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (ch_en[i]) begin
            loc_e = pulse ? EW'(ch_slot[i*SLOT_W +: SLOT_W])
                          : EW'(ch_slot[i*SLOT_W +: SLOT_W] >> 1);
            lim   = pulse ? fl_e : (ch_slot[i*SLOT_W] ? fl_e - half_e : half_e);
            endp  = EW'(fmt_is_late(fmt)) + (loc_e + EW'(1)) * EW'(slot_len);
            if (endp > lim) bad = 1'b1;
            for (int j = i + 1; j < NUM_CH; j++) begin
               if (ch_en[j] && ch_slot[j*SLOT_W +: SLOT_W] == ch_slot[i*SLOT_W +: SLOT_W])
                  bad = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) err <= 1'b0;
      else        err <= bad;
   end
endmodule

// File: rtl/tdm_slot_tx.sv
`timescale 1ns/1ps
module tdm_slot_tx
   import tdm_tx_pkg::*;
#(
   parameter int NUM_CH   = 8,
   parameter int SAMPLE_W = 24,
   parameter int FRAME_W  = 9,
   parameter int SLEN_W   = 6,
   parameter int DIV_HALF = 2,
   localparam int SLOT_W  = $clog2(NUM_CH),
   localparam int WL_W    = $clog2(SAMPLE_W + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [1:0]                 cfg_fmt,
   input  logic [FRAME_W-1:0]         cfg_frame_len,
   input  logic [SLEN_W-1:0]          cfg_slot_len,
   input  logic [WL_W-1:0]            cfg_word_len,
   input  logic [NUM_CH-1:0]          cfg_ch_en,
   input  logic [NUM_CH*SLOT_W-1:0]   cfg_ch_slot,
   input  logic                       s_valid,
   output logic                       s_ready,
   input  logic [NUM_CH*SAMPLE_W-1:0] s_data,
   output logic                       bclk,
   output logic                       lrclk,
   output logic                       txd,
   output logic                       cfg_err
);
   localparam int LOC_W = SLOT_W + 1;
   localparam int IDX_W = $clog2(SAMPLE_W);

   generate
      if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
         $error("NUM_CH must be a power of two, at least 2");
      end
      if (SAMPLE_W < 2)  begin : g_bad_w   $error("SAMPLE_W must be at least 2");  end
      if (DIV_HALF < 1)  begin : g_bad_div $error("DIV_HALF must be at least 1");  end
      if (FRAME_W < 2)   begin : g_bad_fw  $error("FRAME_W must be at least 2");   end
   endgenerate

   logic                       tick, frame_start, running, pos_zero, half, in_region;
   logic [SLEN_W-1:0]          bis;
   logic [LOC_W-1:0]           loc;
   logic [LOC_W:0]             slot_num;
   logic                       bit_ok;
   logic [IDX_W-1:0]           bidx;
   logic [NUM_CH*SAMPLE_W-1:0] hold_q, active_q;
   logic                       full_q;
   logic [NUM_CH-1:0]          ch_bit;

   tdm_tx_bclkgen #(.DIV_HALF(DIV_HALF)) u_bclk (
      .clk(clk), .rst_n(rst_n), .bclk(bclk), .fall_tick(tick)
   );

   tdm_tx_seq #(.FRAME_W(FRAME_W), .SLEN_W(SLEN_W), .LOC_W(LOC_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .tick(tick), .fmt(cfg_fmt),
      .frame_len(cfg_frame_len), .slot_len(cfg_slot_len),
      .running(running), .pos_zero(pos_zero), .second_half(half),
      .in_region(in_region), .bis(bis), .loc(loc), .frame_start(frame_start)
   );

   tdm_tx_cfgchk #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W), .FRAME_W(FRAME_W), .SLEN_W(SLEN_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .fmt(cfg_fmt), .frame_len(cfg_frame_len),
      .slot_len(cfg_slot_len), .ch_en(cfg_ch_en), .ch_slot(cfg_ch_slot), .err(cfg_err)
   );

   // staging register and transmit bank
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q   <= '0;
         active_q <= '0;
         full_q   <= 1'b0;
      end else begin
         if (s_valid && !full_q) begin
            hold_q <= s_data;
            full_q <= 1'b1;
         end
         if (frame_start) begin
            active_q <= full_q ? hold_q : '0;
            if (full_q) full_q <= 1'b0;
         end
      end
   end
   assign s_ready = !full_q;

   // slot number of the current bit and per-channel bit select
   always_comb begin
      slot_num = fmt_is_pulse(cfg_fmt) ? {1'b0, loc} : {loc, half};
      bit_ok   = in_region && (slot_num < (LOC_W+1)'(NUM_CH))
                 && (int'(bis) < int'(cfg_word_len)) && (int'(bis) < SAMPLE_W);
      bidx     = IDX_W'(SAMPLE_W - 1) - IDX_W'(bis);
   end

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic [SAMPLE_W-1:0] smp;
         assign smp       = active_q[c*SAMPLE_W +: SAMPLE_W];
         assign ch_bit[c] = cfg_ch_en[c]
                            && ((LOC_W+1)'(cfg_ch_slot[c*SLOT_W +: SLOT_W]) == slot_num)
                            && smp[bidx];
      end
   endgenerate

   assign txd = bit_ok && (|ch_bit);

   always_comb begin
      unique case (cfg_fmt)
         FMT_HALF:      lrclk = running && half;
         FMT_HALF_LATE: lrclk = running && !half;
         default:       lrclk = running && pos_zero;
      endcase
   end
endmodule

// File: rtl/tdm_slot_tx_chk.sv
`timescale 1ns/1ps
module tdm_slot_tx_chk #(
   parameter int NUM_CH   = 8,
   parameter int DIV_HALF = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_valid,
   input logic              s_ready,
   input logic              bclk,
   input logic              txd,
   input logic [NUM_CH-1:0] cfg_ch_en
);
   int unsigned gap_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              gap_q <= 0;
      else if (!$stable(bclk)) gap_q <= 1;
      else                     gap_q <= gap_q + 1;
   end

   AST_BCLK_RATE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bclk) |-> gap_q == DIV_HALF); // R1
   AST_TXD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(bclk) |-> $stable(txd)); // R1
   AST_READY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      s_valid && s_ready |=> !s_ready); // R8
   AST_QUIET_NO_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ch_en == '0 |-> !txd); // R6
endmodule

bind tdm_slot_tx tdm_slot_tx_chk #(.NUM_CH(NUM_CH), .DIV_HALF(DIV_HALF)) u_chk (
   .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
   .bclk(bclk), .txd(txd), .cfg_ch_en(cfg_ch_en)
);

// File: tb/tdm_slot_tx_tb.sv
`timescale 1ns/1ps
module tdm_slot_tx_tb_top;
   localparam int NCH = 8, SW = 16, FW = 8, LW = 6, DH = 2, SLW = 3, WLW = 5;

   logic            clk = 0, rst_n = 0;
   logic [1:0]      fmt = 1;
   logic [FW-1:0]   fl = 64;
   logic [LW-1:0]   sl = 16;
   logic [WLW-1:0]  wl = 16;
   logic [NCH-1:0]  en = '0;
   logic [SLW-1:0]  smap [NCH];
   logic [SW-1:0]   smp  [NCH];
   logic [NCH*SLW-1:0] ch_slot;
   logic [NCH*SW-1:0]  s_data;
   logic s_valid = 0, s_ready, bclk, lrclk, txd, cfg_err;
   int   errs = 0, checks = 0;

   always #10 clk = ~clk;

   always_comb begin
      for (int c = 0; c < NCH; c++) begin
         ch_slot[c*SLW +: SLW] = smap[c];
         s_data[c*SW +: SW]    = smp[c];
      end
   end

   tdm_slot_tx #(.NUM_CH(NCH), .SAMPLE_W(SW), .FRAME_W(FW), .SLEN_W(LW), .DIV_HALF(DH)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_fmt(fmt), .cfg_frame_len(fl), .cfg_slot_len(sl),
      .cfg_word_len(wl), .cfg_ch_en(en), .cfg_ch_slot(ch_slot), .s_valid(s_valid),
      .s_ready(s_ready), .s_data(s_data), .bclk(bclk), .lrclk(lrclk), .txd(txd), .cfg_err(cfg_err)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_txd(input int p);
      int slot, b, q, half, h;
      if (fmt == 2'd0 || fmt == 2'd1) begin
         q = p - ((fmt == 2'd0) ? 1 : 0);
         if (q < 0) return 0;
         slot = q / int'(sl);
         b    = q % int'(sl);
      end else begin
         half = int'(fl) / 2;
         h    = (p >= half) ? 1 : 0;
         q    = p - h * half - ((fmt == 2'd2) ? 1 : 0);
         if (q < 0) return 0;
         slot = 2 * (q / int'(sl)) + h;
         b    = q % int'(sl);
      end
      if (slot >= NCH || b >= int'(wl)) return 0;
      for (int c = 0; c < NCH; c++)
         if (en[c] && int'(smap[c]) == slot) return int'(smp[c][SW-1-b]);
      return 0;
   endfunction

   function automatic int exp_lr(input int p);
      int half = int'(fl) / 2;
      if (fmt == 2'd3) return (p >= half) ? 1 : 0;
      if (fmt == 2'd2) return (p < half) ? 1 : 0;
      return (p == 0) ? 1 : 0;
   endfunction

   task automatic do_reset(input bit check_it);
      @(negedge clk); rst_n = 0;
      repeat (3) @(negedge clk);
      if (check_it) begin
         chk("R10", "bclk in reset", int'(bclk), 1);
         chk("R10", "lrclk in reset", int'(lrclk), 0);
         chk("R10", "txd in reset", int'(txd), 0);
         chk("R10", "s_ready in reset", int'(s_ready), 1);
      end
      rst_n = 1;
   endtask

   task automatic push();
      @(negedge clk); s_valid = 1;
      @(negedge clk); s_valid = 0;
      chk("R8", "s_ready after accept", int'(s_ready), 0);
   endtask

   // three frames: zero (nothing staged), staged set, zero again (underrun)
   task automatic run_frames(input string req);
      int bad_d = 0, bad_l = 0, bad_z = 0, fp = -1, fa = 0, fe = 0;
      int n_fl = int'(fl);
      do_reset(0);
      for (int n = 0; n < 3 * n_fl; n++) begin
         int p, f;
         @(posedge bclk); #1;
         p = n % n_fl; f = n / n_fl;
         if (f == 1) begin
            if (int'(txd) != exp_txd(p)) begin
               bad_d++;
               if (fp < 0) begin fp = p; fa = int'(txd); fe = exp_txd(p); end
            end
            if (int'(lrclk) != exp_lr(p)) bad_l++;
         end else if (txd) bad_z++;
         if (n == 0) push();
      end
      chk(req, $sformatf("data bit mismatches (first at bit %0d act %0d exp %0d)", fp, fa, fe), bad_d, 0);
      chk(req, "frame clock mismatches", bad_l, 0);
      chk("R8", "nonzero bits in unstaged frames", bad_z, 0);
   endtask

   task automatic t_reset_and_rate();
      time t1, t2;
      en = '0;
      do_reset(1);
      @(posedge bclk); t1 = $time;
      @(posedge bclk); t2 = $time;
      chk("R1", "bclk period ns", int'(t2 - t1), 2 * DH * 20);
   endtask

   task automatic t_pulse_shuffled();
      fmt = 2'd1; fl = 64; sl = 16; wl = 16; en = 8'h0F;
      smap[0] = 3; smap[1] = 0; smap[2] = 2; smap[3] = 1;
      run_frames("R2 R6");
   endtask

   task automatic t_pulse_late_short_word();
      fmt = 2'd0; fl = 48; sl = 8; wl = 6; en = 8'b0010_0101;
      smap[0] = 1; smap[2] = 4; smap[5] = 0;
      run_frames("R3 R7");
   endtask

   task automatic t_half();
      fmt = 2'd3; fl = 64; sl = 16; wl = 12; en = 8'h0F;
      for (int c = 0; c < 4; c++) smap[c] = SLW'(c);
      run_frames("R4 R7");
   endtask

   task automatic t_half_late();
      fmt = 2'd2; fl = 64; sl = 12; wl = 10; en = 8'b0101_0010;
      smap[1] = 0; smap[4] = 3; smap[6] = 2;
      run_frames("R5 R6");
   endtask

   task automatic cfg_case(input string what, input int exp);
      do_reset(0);
      repeat (2) @(negedge clk);
      chk("R9", what, int'(cfg_err), exp);
   endtask

   task automatic t_cfg();
      for (int c = 0; c < NCH; c++) smap[c] = SLW'(c);
      fmt = 2'd1; fl = 64; sl = 16; en = 8'h0F;   cfg_case("legal pulse map", 0);
      smap[3] = 1;                                 cfg_case("shared slot", 1);
      smap[3] = 3; fl = 32; en = 8'h04;            cfg_case("pulse slot past frame", 1);
      fmt = 2'd2; fl = 64; en = 8'h04;             cfg_case("delayed half slot overrun", 1);
      fmt = 2'd3;                                  cfg_case("half slot fits exactly", 0);
   endtask

   initial begin
      for (int c = 0; c < NCH; c++) begin
         smap[c] = SLW'(NCH - 1 - c);
         smp[c]  = SW'(16'hA5C3 ^ (c * 16'h1357));
      end
      t_reset_and_rate();
      t_pulse_shuffled();
      t_pulse_late_short_word();
      t_half();
      t_half_late();
      t_cfg();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule